// File: doc/BRIEF.md
# Quarter-Duty LCD Waveform Sequencer

This block produces the drive codes for a multiplexed segment display with four common lines and eighteen segment lines, run at one-quarter duty and one-third bias. Each output is a 2-bit code that selects one of four supply levels built outside the block: the full drive level VC, two thirds of it (V1), one third of it (V2), and ground (VSS). The analog switches that turn the codes into voltages are also outside the block.

A display clock enable paces the block. A programmable count of enable pulses sets the length of each half slot. The block walks through the four common slots. Each slot has two halves of opposite polarity, so the panel sees no net DC. In every slot one common is selected, and the eighteen segments are driven from the display memory, which is a flat input holding one 4-bit entry per segment. A small mode register, written from the command side, chooses one of three patterns: every segment dark, every segment lit, or the memory contents. The mode only selects the pattern and never alters the stored data.

Top module: `lcd_quarter_seq`

## Requirements
- R1: While reset is applied and after it is released, before any enable pulse or mode write, the block is in slot 0, first half, with the mode blank. COM1 is then at VC, COM2 to COM4 are at V2, and every segment is at V1.
- R2: The level codes are 2'b00 for VSS, 2'b01 for V2, 2'b10 for V1 and 2'b11 for VC. Common k (COM1 is k=0) is on com_lvl[2k+1:2k]. Segment i (0-based) is on seg_lvl[2i+1:2i] and reads ram_flat[4i+3:4i].
- R3: In slot k only common k is selected. In the first half the selected common is at VC and the others are at V2. In the second half the selected common is at VSS and the others are at V1.
- R4: A lit segment is at VSS in the first half and VC in the second half. A dark segment is at V1 in the first half and V2 in the second half.
- R5: In memory mode (code 2'b10), segment i is lit in slot k exactly when bit 3-k of its entry is 1. Bit 3 belongs to COM1 and bit 0 belongs to COM4.
- R6: In all-lit mode (code 2'b01), every segment is lit whatever the memory holds.
- R7: In blank mode (code 2'b00), every segment is dark whatever the memory holds.
- R8: A mode write with the code 2'b11 is ignored, and the previous mode stays in force.
- R9: Each half slot lasts half_len+1 enable pulses. Cycles without the enable change nothing. The order of halves is slot0/first, slot0/second, slot1/first and so on up to slot3/second, then it returns to slot0/first.
- R10: A mode write takes effect on the outputs in the cycle after the clock edge that samples mode_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| disp_ce | input | 1 | Display clock enable, one pulse per display tick |
| half_len | input | 8 | Enable pulses per half slot, minus one |
| mode_we | input | 1 | Mode write strobe |
| mode_in | input | 2 | Mode code: 00 blank, 01 all lit, 10 memory, 11 reserved |
| ram_flat | input | 72 | Display memory, one 4-bit entry per segment |
| com_lvl | output | 8 | Common level codes, two bits per common |
| seg_lvl | output | 36 | Segment level codes, two bits per segment |

## Verification
A mode write and a half-slot step can land on the same clock edge. When they do, the segment codes change both their polarity and their pattern at once, and a mistake in ordering would leave one of the two stale. The random run pulses the enable on about half of all cycles and writes a mode, sometimes the reserved code, on about one cycle in eight, so the two coincide often. Each cycle is judged by a reference model in the bench that applies both updates before it computes the expected common and segment codes. Short half lengths, including zero, make phase steps dense. This also tests the wrap from slot 3 back to slot 0 while the mode is changing.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  localparam int COM_N  = 4;
  localparam int SLOT_W = $clog2(COM_N);

  // drive level codes
  localparam logic [1:0] LV_VSS = 2'b00;
  localparam logic [1:0] LV_V2  = 2'b01;
  localparam logic [1:0] LV_V1  = 2'b10;
  localparam logic [1:0] LV_VC  = 2'b11;

  // display mode codes
  localparam logic [1:0] MD_BLANK = 2'b00;
  localparam logic [1:0] MD_LIT   = 2'b01;
  localparam logic [1:0] MD_RAM   = 2'b10;
  localparam logic [1:0] MD_RSV   = 2'b11;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic              half;
  } phase_t;

endpackage

// File: rtl/lcdseq_timer.sv
module lcdseq_timer
  import lcdseq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [DIV_W-1:0] half_len,
  output phase_t           phase
);

  localparam int PH_W = SLOT_W + 1;

  logic [DIV_W-1:0] tick_q, tick_d;
  phase_t           phase_q, phase_d;

  always_comb begin
    tick_d  = tick_q;
    phase_d = phase_q;
    if (ce) begin
      if (tick_q >= half_len) begin
        tick_d  = '0;
        phase_d = phase_t'(PH_W'(phase_q) + PH_W'(1));
      end else begin
        tick_d = tick_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      phase_q <= '0;
    end else begin
      tick_q  <= tick_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(phase_q)); // R9

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase_q == $past(phase_q)) ||
             (PH_W'(phase_q) == PH_W'(PH_W'($past(phase_q)) + PH_W'(1)))); // R9

endmodule

// File: rtl/lcdseq_mode.sv
module lcdseq_mode
  import lcdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] wdata,
  output logic [1:0] mode
);

  logic [1:0] mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (we && (wdata != MD_RSV)) begin
      mode_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_BLANK;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign mode = mode_q;

  AST_MODE_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata == MD_RSV) |=> $stable(mode_q)); // R8

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != MD_RSV); // R8

endmodule

// File: rtl/lcdseq_com.sv
module lcdseq_com
  import lcdseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  phase_t           phase,
  output logic [2*COM_N-1:0] com_lvl
);

  logic [COM_N-1:0] extreme;

  for (genvar k = 0; k < COM_N; k++) begin : g_com
    logic sel;
    assign sel = (phase.slot == SLOT_W'(k));
    always_comb begin
      if (!phase.half) com_lvl[2*k +: 2] = sel ? LV_VC  : LV_V2;
      else             com_lvl[2*k +: 2] = sel ? LV_VSS : LV_V1;
    end
    assign extreme[k] = (com_lvl[2*k] == com_lvl[2*k+1]);
  end

  AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(extreme) == 1); // R3

endmodule

// File: rtl/lcdseq_seg.sv
module lcdseq_seg
  import lcdseq_pkg::*;
#(
  parameter int SEG_N = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  phase_t                 phase,
  input  logic [1:0]             mode,
  input  logic [COM_N*SEG_N-1:0] ram,
  output logic [2*SEG_N-1:0]     seg_lvl
);

  logic [SEG_N-1:0]  extreme;
  logic [SLOT_W-1:0] bit_sel;

  // slot k reads entry bit COM_N-1-k
  assign bit_sel = ~phase.slot;

  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    logic [COM_N-1:0] entry;
    logic             lit;
    assign entry = ram[COM_N*i +: COM_N];
    assign lit   = (mode == MD_LIT) || ((mode == MD_RAM) && entry[bit_sel]);
    always_comb begin
      if (!phase.half) seg_lvl[2*i +: 2] = lit ? LV_VSS : LV_V1;
      else             seg_lvl[2*i +: 2] = lit ? LV_VC  : LV_V2;
    end
    assign extreme[i] = (seg_lvl[2*i] == seg_lvl[2*i+1]);
  end

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_BLANK) |-> (extreme == '0)); // R7

  AST_LIT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_LIT) |-> (&extreme)); // R6

endmodule

// File: rtl/lcd_quarter_seq.sv
module lcd_quarter_seq
  import lcdseq_pkg::*;
#(
  parameter int SEG_N = 18,
  parameter int DIV_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_ce,
  input  logic [DIV_W-1:0]       half_len,
  input  logic                   mode_we,
  input  logic [1:0]             mode_in,
  input  logic [COM_N*SEG_N-1:0] ram_flat,
  output logic [2*COM_N-1:0]     com_lvl,
  output logic [2*SEG_N-1:0]     seg_lvl
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  phase_t     phase;
  logic [1:0] mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  lcdseq_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ce       (disp_ce),
    .half_len (half_len),
    .phase    (phase)
  );

  lcdseq_mode u_mode (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (mode_we),
    .wdata (mode_in),
    .mode  (mode)
  );

  lcdseq_com u_com (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .phase   (phase),
    .com_lvl (com_lvl)
  );

  lcdseq_seg #(.SEG_N(SEG_N)) u_seg (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .phase   (phase),
    .mode    (mode),
    .ram     (ram_flat),
    .seg_lvl (seg_lvl)
  );

  AST_RESET_HOME: assert property (@(posedge clk)
    !rst_core_n |=> (com_lvl[1:0] == LV_VC || rst_core_n)); // R1

endmodule

// File: tb/sim_lcd_quarter_seq.sv
module sim_lcd_quarter_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        disp_ce;
  logic [7:0]  half_len;
  logic        mode_we;
  logic [1:0]  mode_in;
  logic [71:0] ram_flat;
  logic [7:0]  com_lvl;
  logic [35:0] seg_lvl;

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [1:0] m_slot;
  logic       m_half;
  logic [1:0] m_mode;
  int         m_tick;

  always #2 clk = ~clk;

  lcd_quarter_seq u0 (
    .clk(clk), .rst_n(rst_n), .disp_ce(disp_ce), .half_len(half_len),
    .mode_we(mode_we), .mode_in(mode_in), .ram_flat(ram_flat),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // R2: codes 00 VSS, 01 V2, 10 V1, 11 VC
  function automatic logic [7:0] exp_com(logic [1:0] s, logic h);
    logic [7:0] v;
    for (int k = 0; k < 4; k++) begin
      if (!h) v[2*k +: 2] = (k == int'(s)) ? 2'b11 : 2'b01;
      else    v[2*k +: 2] = (k == int'(s)) ? 2'b00 : 2'b10;
    end
    return v;
  endfunction

  function automatic logic [35:0] exp_seg(logic [1:0] md, logic [1:0] s,
                                          logic h, logic [71:0] r);
    logic [35:0] v;
    for (int i = 0; i < 18; i++) begin
      logic on;
      on = (md == 2'b01) || (md == 2'b10 && r[4*i + 3 - int'(s)]);
      if (!h) v[2*i +: 2] = on ? 2'b00 : 2'b10;
      else    v[2*i +: 2] = on ? 2'b11 : 2'b01;
    end
    return v;
  endfunction

  function automatic string seg_tag(logic [1:0] md);
    if (md == 2'b01) return "R6";
    if (md == 2'b10) return "R5";
    return "R7";
  endfunction

  task automatic check_all(string ctag, string stag);
    logic [7:0]  ec;
    logic [35:0] es;
    ec = exp_com(m_slot, m_half);
    es = exp_seg(m_mode, m_slot, m_half, ram_flat);
    total++;
    if (com_lvl !== ec) begin
      bad++;
      $display("FAIL %s com_lvl actual=%h expected=%h", ctag, com_lvl, ec);
    end
    total++;
    if (seg_lvl !== es) begin
      bad++;
      $display("FAIL %s seg_lvl actual=%h expected=%h", stag, seg_lvl, es);
    end
  endtask

  task automatic step(logic ce, logic we, logic [1:0] wd, logic [71:0] r);
    @(negedge clk);
    disp_ce = ce; mode_we = we; mode_in = wd; ram_flat = r;
    @(posedge clk);
    if (we && wd != 2'b11) m_mode = wd;
    if (ce) begin
      if (m_tick >= int'(half_len)) begin
        m_tick = 0;
        {m_slot, m_half} = {m_slot, m_half} + 3'd1;
      end else begin
        m_tick++;
      end
    end
    #1;
  endtask

  task automatic do_reset(logic [7:0] hl);
    @(negedge clk);
    rst_n = 1'b0; disp_ce = 1'b0; mode_we = 1'b0; mode_in = 2'b00;
    half_len = hl;
    m_slot = 2'd0; m_half = 1'b0; m_mode = 2'b00; m_tick = 0;
    repeat (3) @(negedge clk);
    check_all("R1", "R1");
    rst_n = 1'b1;
    for (int n = 0; n < 3; n++) step(1'b0, 1'b0, 2'b00, ram_flat);
    check_all("R1", "R1");
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b1; disp_ce = 1'b0; mode_we = 1'b0; mode_in = 2'b00;
    half_len = 8'd0; ram_flat = 72'h9_3C5A_F00F_1234_8421;

    // R1 reset state, then R9 sequence with one pulse per half, incl. wrap
    do_reset(8'd0);
    for (int n = 0; n < 10; n++) begin
      step(1'b1, 1'b0, 2'b00, ram_flat);
      check_all("R9", "R4");
    end

    // R9 half length 2: three pulses per half, idle cycles hold
    do_reset(8'd2);
    step(1'b1, 1'b0, 2'b00, ram_flat); check_all("R9", "R9");
    step(1'b0, 1'b0, 2'b00, ram_flat); check_all("R9", "R9");
    step(1'b1, 1'b0, 2'b00, ram_flat); check_all("R9", "R9");
    step(1'b1, 1'b0, 2'b00, ram_flat); check_all("R9", "R9");
    total++;
    if (com_lvl[1:0] !== 2'b00) begin
      bad++;
      $display("FAIL R9 com1 second half actual=%b expected=00", com_lvl[1:0]);
    end

    // R10 / R6: all-lit takes effect after the write edge
    step(1'b0, 1'b1, 2'b01, ram_flat); check_all("R3", "R6");
    // R8: reserved code ignored, stays all-lit
    step(1'b0, 1'b1, 2'b11, ram_flat); check_all("R3", "R8");
    // R5: memory mode, every slot and half, with R10 coinciding phase step
    step(1'b1, 1'b1, 2'b10, 72'hF_0000_0000_0000_8421); check_all("R3", "R5");
    for (int n = 0; n < 24; n++) begin
      step(1'b1, 1'b0, 2'b00, ram_flat);
      check_all("R3", "R5");
    end
    // R7: blank ignores full memory
    step(1'b0, 1'b1, 2'b00, {72{1'b1}}); check_all("R3", "R7");

    // random run with coincident mode writes and phase steps
    for (int seg_run = 0; seg_run < 4; seg_run++) begin
      do_reset(8'($urandom_range(0, 3)));
      for (int n = 0; n < 800; n++) begin
        logic [71:0] r;
        logic        we;
        r  = {8'($urandom), 32'($urandom), 32'($urandom)};
        we = ($urandom_range(0, 7) == 0);
        step(1'($urandom_range(0, 1)), we, 2'($urandom_range(0, 3)),
             ($urandom_range(0, 3) == 0) ? r : ram_flat);
        check_all("R3", seg_tag(m_mode));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule